// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the shift stage of a small processor datapath. It is purely combinational. It takes a 32-bit operand, a two-bit shift kind and an 8-bit shift amount. A select input says whether the amount is an instruction immediate or the low byte of a register. The incoming carry flag is also an input. In the same cycle it returns the shifted value, the new carry flag, and the negative and zero flags of the value.

The special amounts follow fixed rules:

- **Zero amounts.** A register amount of zero leaves the operand and the carry untouched. An immediate zero means a shift by the full width for the two right shifts. An immediate zero passes the operand through for a left shift or a rotate.
- **Large amounts.** Amounts equal to or above the width give well-defined results and carries.
- **Rotate amounts.** A rotate uses the amount modulo the width.

The result of every shift kind is built from one shared logarithmic right-rotator. A left shift reverses the bits before and after it. A mask then clears the vacated bits, or fills them with the sign.

The block has no clock and no state. There are no states or transitions to name.

Top module: `barrel_shift_unit`

## Requirements
- R1: With `amt_reg_i`=1 all eight bits of `amt_i` form the amount. With `amt_reg_i`=0 only `amt_i[4:0]` is used, and bits 7:5 have no effect on any output.
- R2: A register amount of 0 returns `res_o` = `opnd_i` and `carry_o` = `carry_i` for every shift kind.
- R3: For kind 2'b00 (logical left) and amounts n from 1 to 31, `res_o` is the operand shifted left by n and `carry_o` is operand bit 32-n.
- R4: For kind 2'b00, an amount of exactly 32 gives a result of 0 with carry = operand bit 0. An amount above 32 gives 0 with carry 0.
- R5: For kind 2'b01 (logical right):
  - n from 1 to 31 gives the operand shifted right with zero fill and carry = bit n-1.
  - n = 32 gives 0 with carry = bit 31.
  - n above 32 gives 0 with carry 0.
- R6: For kind 2'b10 (arithmetic right):
  - n from 1 to 31 shifts in copies of bit 31, with carry = bit n-1.
  - n of 32 or more gives all bits equal to bit 31, with carry = bit 31.
- R7: For kind 2'b11 (rotate right), let m be the low five bits of the amount. A nonzero m rotates right by m, with carry = bit m-1 of the unrotated operand. A nonzero register amount with m = 0 returns the operand with carry = bit 31.
- R8: An immediate amount of 0 with kind 2'b01 or 2'b10 acts as an amount of 32.
- R9: An immediate amount of 0 with kind 2'b00 or 2'b11 returns the operand with the carry unchanged.
- R10: `neg_o` equals bit 31 of `res_o`, and `zero_o` is 1 exactly when `res_o` is 0. This holds for every case, including pass-through.
- R11: All outputs follow the inputs with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Value to shift |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_i | input | 8 | Shift amount; low five bits only when immediate |
| amt_reg_i | input | 1 | 1: amount taken from a register byte; 0: immediate |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry flag |
| neg_o | output | 1 | Bit 31 of the result |
| zero_o | output | 1 | Result equals zero |

## Verification
Every output of this block is due in the same cycle as the inputs that produce it, with zero registers on the path. The bench drives each stimulus on a falling clock edge and queues the expected value. A monitor compares it on the next rising edge, half a period later, when the combinational paths have long settled. One extra check changes the operand between edges and samples one nanosecond later. It shows that the result does not wait for any clock.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/bsu_amount_decode.sv
// Turns the raw amount and its source into a normalised effective amount
// plus the special-case flags the shift core needs.
module bsu_amount_decode
    import bsu_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_W    = $clog2(WIDTH)
) (
    input  shift_kind_e         kind,
    input  logic [AMT_BITS-1:0] amt,
    input  logic                amt_reg,
    output logic                bypass,
    output logic [SH_W-1:0]     n_lo,
    output logic                at_width,
    output logic                beyond,
    output logic                wrap
);

    localparam int EW = AMT_BITS + 1;
    localparam logic [EW-1:0] FULL = EW'(WIDTH);

    logic [EW-1:0]   eff;
    logic [SH_W-1:0] imm_n;

    assign imm_n = amt[SH_W-1:0];

    always_comb begin
        bypass = 1'b0;
        eff    = EW'(imm_n);
        if (amt_reg) begin
            eff    = {1'b0, amt};
            bypass = (amt == '0);
        end else if (imm_n == '0) begin
            unique case (kind)
                SH_LSR, SH_ASR: eff    = FULL;
                default:        bypass = 1'b1;
            endcase
        end
    end

    assign n_lo     = eff[SH_W-1:0];
    assign at_width = (eff == FULL);
    assign beyond   = (eff > FULL);
    assign wrap     = (kind == SH_ROR) && !bypass && (n_lo == '0);

endmodule

// File: rtl/bsu_rotr.sv
// Logarithmic right rotator: one mux stage per amount bit.
module bsu_rotr #(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SH_W-1:0]  amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][S-1:0], stage[k][WIDTH-1:S]}
                                   : stage[k];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/bsu_core.sv
// Builds all four shift kinds from one rotator, then applies the
// pass-through, full-width and beyond-width overrides.
module bsu_core
    import bsu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd,
    input  shift_kind_e      kind,
    input  logic [SH_W-1:0]  n_lo,
    input  logic             bypass,
    input  logic             at_width,
    input  logic             beyond,
    input  logic             wrap,
    input  logic             carry_in,
    output logic [WIDTH-1:0] res,
    output logic             carry
);

    function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
        return r;
    endfunction

    logic [WIDTH-1:0] rot_in, rot_out, mask, shaped;
    logic [SH_W-1:0]  lsl_idx, rsh_idx;
    logic             sign, norm_carry;

    assign sign    = opnd[WIDTH-1];
    assign rot_in  = (kind == SH_LSL) ? flip(opnd) : opnd;
    assign mask    = {WIDTH{1'b1}} >> n_lo;
    assign lsl_idx = ~n_lo + SH_W'(1);
    assign rsh_idx = n_lo - SH_W'(1);

    bsu_rotr #(.WIDTH(WIDTH)) u_rot (
        .din  (rot_in),
        .amt  (n_lo),
        .dout (rot_out)
    );

    always_comb begin
        unique case (kind)
            SH_LSL: begin
                shaped     = flip(rot_out & mask);
                norm_carry = opnd[lsl_idx];
            end
            SH_LSR: begin
                shaped     = rot_out & mask;
                norm_carry = opnd[rsh_idx];
            end
            SH_ASR: begin
                shaped     = (rot_out & mask) | ({WIDTH{sign}} & ~mask);
                norm_carry = opnd[rsh_idx];
            end
            default: begin
                shaped     = rot_out;
                norm_carry = opnd[rsh_idx];
            end
        endcase
    end

    always_comb begin
        res   = shaped;
        carry = norm_carry;
        if (bypass) begin
            res   = opnd;
            carry = carry_in;
        end else begin
            unique case (kind)
                SH_LSL, SH_LSR: begin
                    if (at_width) begin
                        res   = '0;
                        carry = (kind == SH_LSL) ? opnd[0] : sign;
                    end else if (beyond) begin
                        res   = '0;
                        carry = 1'b0;
                    end
                end
                SH_ASR: begin
                    if (at_width || beyond) begin
                        res   = {WIDTH{sign}};
                        carry = sign;
                    end
                end
                default: begin
                    if (wrap) begin
                        res   = opnd;
                        carry = sign;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import bsu_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8
) (
    input  logic [WIDTH-1:0]    opnd_i,
    input  logic [1:0]          kind_i,
    input  logic [AMT_BITS-1:0] amt_i,
    input  logic                amt_reg_i,
    input  logic                carry_i,
    output logic [WIDTH-1:0]    res_o,
    output logic                carry_o,
    output logic                neg_o,
    output logic                zero_o
);

    localparam int SH_W = $clog2(WIDTH);

    shift_kind_e     kind;
    logic            bypass, at_width, beyond, wrap;
    logic [SH_W-1:0] n_lo;

    assign kind = shift_kind_e'(kind_i);

    bsu_amount_decode #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_dec (
        .kind     (kind),
        .amt      (amt_i),
        .amt_reg  (amt_reg_i),
        .bypass   (bypass),
        .n_lo     (n_lo),
        .at_width (at_width),
        .beyond   (beyond),
        .wrap     (wrap)
    );

    bsu_core #(.WIDTH(WIDTH)) u_core (
        .opnd     (opnd_i),
        .kind     (kind),
        .n_lo     (n_lo),
        .bypass   (bypass),
        .at_width (at_width),
        .beyond   (beyond),
        .wrap     (wrap),
        .carry_in (carry_i),
        .res      (res_o),
        .carry    (carry_o)
    );

    assign neg_o  = res_o[WIDTH-1];
    assign zero_o = (res_o == '0);

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8
) (
    input logic [WIDTH-1:0]    opnd_i,
    input logic [1:0]          kind_i,
    input logic [AMT_BITS-1:0] amt_i,
    input logic                amt_reg_i,
    input logic                carry_i,
    input logic [WIDTH-1:0]    res_o,
    input logic                carry_o,
    input logic                neg_o,
    input logic                zero_o
);

    localparam int SH_W = $clog2(WIDTH);
    localparam logic [AMT_BITS-1:0] FULL = AMT_BITS'(WIDTH);

    logic known;
    assign known = !$isunknown({opnd_i, kind_i, amt_i, amt_reg_i, carry_i});

    always_comb begin
        if (known) begin
            if (amt_reg_i && amt_i == '0)
                a_r2_reg_zero_bypass: assert (res_o == opnd_i && carry_o == carry_i)
                    else $error("R2 register zero amount altered operand or carry");
            if (amt_reg_i && kind_i == 2'b00 && amt_i > FULL)
                a_r4_lsl_beyond: assert (res_o == '0 && !carry_o)
                    else $error("R4 left shift beyond width not cleared");
            if (amt_reg_i && kind_i == 2'b10 && amt_i >= FULL)
                a_r6_asr_fill: assert (res_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1])
                    else $error("R6 arithmetic shift not sign filled");
            if (amt_reg_i && kind_i == 2'b11 && amt_i != '0 && amt_i[SH_W-1:0] == '0)
                a_r7_ror_wrap: assert (res_o == opnd_i && carry_o == opnd_i[WIDTH-1])
                    else $error("R7 full rotate changed value or carry");
            if (!amt_reg_i && kind_i == 2'b00 && amt_i[SH_W-1:0] == '0)
                a_r9_lsl_imm_zero: assert (res_o == opnd_i && carry_o == carry_i)
                    else $error("R9 immediate zero left shift not pass-through");
            a_r10_zero_flag: assert (!zero_o || (res_o == '0 && !neg_o))
                else $error("R10 zero flag inconsistent with result");
        end
    end

endmodule

bind barrel_shift_unit bsu_checker #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_chk (
    .opnd_i    (opnd_i),
    .kind_i    (kind_i),
    .amt_i     (amt_i),
    .amt_reg_i (amt_reg_i),
    .carry_i   (carry_i),
    .res_o     (res_o),
    .carry_o   (carry_o),
    .neg_o     (neg_o),
    .zero_o    (zero_o)
);

// File: tb/sim_barrel_shift_unit.sv
module sim_barrel_shift_unit;

    localparam int W = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [W-1:0] opnd  = '0;
    logic [1:0]   kind  = 2'b00;
    logic [7:0]   amt   = '0;
    logic         amt_reg = 1'b0;
    logic         cin   = 1'b0;
    logic [W-1:0] res;
    logic         cout, neg, zero;

    barrel_shift_unit u0 (
        .opnd_i    (opnd),
        .kind_i    (kind),
        .amt_i     (amt),
        .amt_reg_i (amt_reg),
        .carry_i   (cin),
        .res_o     (res),
        .carry_o   (cout),
        .neg_o     (neg),
        .zero_o    (zero)
    );

    typedef struct {
        logic [W-1:0] res;
        logic         c;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Behavioural model written from the requirements: returns {carry, result}.
    function automatic logic [W:0] model(input logic [W-1:0] o, input logic [1:0] k,
                                         input logic [7:0] a, input logic r, input logic c);
        int n;
        int m;
        if (r) begin
            n = int'(a);
            if (n == 0) return {c, o};
        end else begin
            n = int'(a[4:0]);
            if (n == 0) begin
                if (k == 2'b01 || k == 2'b10) n = 32;
                else return {c, o};
            end
        end
        case (k)
            2'b00: begin
                if (n < 32)       return {o[32-n], o << n};
                else if (n == 32) return {o[0], 32'h0};
                else              return {1'b0, 32'h0};
            end
            2'b01: begin
                if (n < 32)       return {o[n-1], o >> n};
                else if (n == 32) return {o[31], 32'h0};
                else              return {1'b0, 32'h0};
            end
            2'b10: begin
                if (n < 32) return {o[n-1], W'($signed(o) >>> n)};
                else        return {o[31], {W{o[31]}}};
            end
            default: begin
                m = n % 32;
                if (m == 0) return {o[31], o};
                return {o[m-1], (o >> m) | (o << (32 - m))};
            end
        endcase
    endfunction

    function automatic string pick_tag(input logic [1:0] k, input logic [7:0] a, input logic r);
        if (r && a == 0) return "R2";
        if (!r && a[4:0] == 0) return (k == 2'b01 || k == 2'b10) ? "R8" : "R9";
        case (k)
            2'b00:   return (r && a >= 32) ? "R4" : "R3";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] o, input logic [1:0] k, input logic [7:0] a,
                         input logic r, input logic c, input string t);
        exp_t e;
        logic [W:0] m;
        @(negedge clk);
        opnd = o; kind = k; amt = a; amt_reg = r; cin = c;
        m     = model(o, k, a, r, c);
        e.res = m[W-1:0];
        e.c   = m[W];
        e.tag = (t == "") ? pick_tag(k, a, r) : t;
        sb.push_back(e);
    endtask

    // Monitor: result is due half a period after the driving falling edge.
    always @(posedge clk) begin
        exp_t e;
        if (rst_n && sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (res !== e.res || cout !== e.c) begin
                errors++;
                $display("FAIL %s: res=%h carry=%b expected res=%h carry=%b",
                         e.tag, res, cout, e.res, e.c);
            end
            checks++;
            if (neg !== e.res[W-1] || zero !== (e.res == '0)) begin
                errors++;
                $display("FAIL R10: neg=%b zero=%b expected neg=%b zero=%b",
                         neg, zero, e.res[W-1], (e.res == '0));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // idle state: immediate zero left shift of zero (R9, R10)
        checks++;
        if (res !== '0 || cout !== 1'b0 || zero !== 1'b1 || neg !== 1'b0) begin
            errors++;
            $display("FAIL R9: idle res=%h carry=%b zero=%b expected 0 0 1", res, cout, zero);
        end
        rst_n = 1'b1;

        // R3 / R4 left shifts
        apply(32'h8000_0001, 2'b00, 8'd1,   1'b1, 1'b0, "R3");
        apply(32'h0000_0003, 2'b00, 8'd31,  1'b1, 1'b0, "R3");
        apply(32'h0000_0001, 2'b00, 8'd32,  1'b1, 1'b0, "R4");
        apply(32'hFFFF_FFFF, 2'b00, 8'd33,  1'b1, 1'b1, "R4");
        // R5 logical right
        apply(32'h0000_0001, 2'b01, 8'd1,   1'b1, 1'b0, "R5");
        apply(32'h8000_0000, 2'b01, 8'd32,  1'b1, 1'b0, "R5");
        apply(32'hFFFF_FFFF, 2'b01, 8'd40,  1'b1, 1'b1, "R5");
        // R6 arithmetic right
        apply(32'h8000_0010, 2'b10, 8'd4,   1'b1, 1'b1, "R6");
        apply(32'h8000_0000, 2'b10, 8'd200, 1'b1, 1'b0, "R6");
        apply(32'h7FFF_FFFF, 2'b10, 8'd32,  1'b1, 1'b1, "R6");
        // R7 rotate
        apply(32'h1234_5678, 2'b11, 8'd8,   1'b1, 1'b1, "R7");
        apply(32'h8000_0000, 2'b11, 8'd32,  1'b1, 1'b0, "R7");
        apply(32'h0000_0001, 2'b11, 8'd64,  1'b1, 1'b1, "R7");
        apply(32'h0000_000F, 2'b11, 8'd4,   1'b0, 1'b0, "R7");
        // R2 register zero, every kind, both carries
        for (int k = 0; k < 4; k++) begin
            apply(32'hA5A5_0F0F, 2'(k), 8'd0, 1'b1, 1'b1, "R2");
            apply(32'h0000_0000, 2'(k), 8'd0, 1'b1, 1'b0, "R2");
        end
        // R8 immediate zero right shifts act as 32
        apply(32'h8000_0000, 2'b01, 8'd0, 1'b0, 1'b0, "R8");
        apply(32'h8000_0000, 2'b10, 8'd0, 1'b0, 1'b0, "R8");
        // R9 immediate zero left shift / rotate pass-through
        apply(32'h0000_0005, 2'b00, 8'd0, 1'b0, 1'b1, "R9");
        apply(32'h8000_0005, 2'b11, 8'd0, 1'b0, 1'b0, "R9");
        // R1 immediate upper bits ignored
        apply(32'h0000_0001, 2'b00, 8'hE3, 1'b0, 1'b0, "R1");
        apply(32'h8000_0000, 2'b01, 8'hE0, 1'b0, 1'b0, "R1");
        apply(32'hF000_0000, 2'b10, 8'hA2, 1'b0, 1'b1, "R1");

        // random sweep
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = 8'($urandom);
            if (i % 4 == 0) a = 8'($urandom_range(0, 40));
            apply($urandom, 2'($urandom), a, 1'($urandom), 1'($urandom), "");
        end

        repeat (2) @(negedge clk);
        // R11: result follows inputs between clock edges
        opnd = 32'h0000_0100; kind = 2'b01; amt = 8'd4; amt_reg = 1'b1; cin = 1'b0;
        #1;
        checks++;
        if (res !== 32'h0000_0010) begin
            errors++;
            $display("FAIL R11: res=%h expected res=%h", res, 32'h0000_0010);
        end
        opnd = 32'h0000_0F00;
        #1;
        checks++;
        if (res !== 32'h0000_00F0) begin
            errors++;
            $display("FAIL R11: res=%h expected res=%h", res, 32'h0000_00F0);
        end

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule